// File: doc/BRIEF.md
# Indexed Real-Time Clock Register Interface

This block is a small clock-calendar register file that software reaches through two byte ports. A write to the index port selects one internal location. Reads and writes on the data port then act on that location. Seven calendar locations (seconds, minutes, hours, weekday, day of month, month, year) hold plain binary bytes exactly as software wrote them. The block does not advance them on its own.

Four control locations govern the block. One reports a fixed timebase and rate setting along with an update-in-progress flag that flips on every read. One holds the periodic-interrupt enable. One reports and clears pending interrupt flags. The fourth is not implemented. A prescaler divides the system clock down to a 1024 Hz event rate while the periodic interrupt is enabled. Each event raises the interrupt output, which stays high until software reads the flag location. Accesses that the block cannot honour produce a one-cycle error pulse. The alarm locations always read as zero.

Top module: `rtc_index_port`

## Requirements
- R1: While reset is high and in the cycle after it is released, `rdata`, `err` and `irq` are 0 and the index register holds 0x00.
- R2: A write on the index port (`port_sel`=0) stores `wdata`. A read on the index port returns the stored index on `rdata` in the next cycle.
- R3: Data writes at indices 0x00, 0x02, 0x04, 0x06, 0x07, 0x08 and 0x09 store the byte. A data read at those indices returns the stored byte in the next cycle, with no error.
- R4: Indices 0x01, 0x03 and 0x05 (alarm locations) read as 0x00. Writes to them are ignored and raise no error.
- R5: A data read at index 0x0A returns `{flag, 7'h26}`. The flag is 0 after reset and inverts after each such read.
- R6: A data write of 0x26 to index 0x0A raises no error. Any other value pulses `err`.
- R7: A data read at index 0x0B returns 0x06, with bit 6 set while the periodic interrupt is enabled. The periodic interrupt is enabled after reset, so the first read gives 0x46.
- R8: A data write to index 0x0B is accepted only if the byte, with bits 6 and 3 cleared, equals 0x06. An accepted write copies bit 6 into the enable. A rejected write pulses `err` and leaves the enable unchanged.
- R9: Once enabled, an event sets the pending flag exactly DIV system cycles after the enabling write, and every DIV cycles after that (DIV = CLK_FREQ_HZ / PIRQ_HZ). An accepted write with bit 6 set while the interrupt already runs keeps the event phase.
- R10: While the enable is clear, no event occurs, so `irq` stays low once the pending flag has been cleared.
- R11: A data read at index 0x0C returns 0xC0 if an event is pending and 0x00 otherwise (bits 5..0 always 0). The read clears the pending flag, and `irq` drops in the same cycle the data appears. An event in the same cycle as the read takes priority over the clear.
- R12: Data writes to 0x0C or 0x0D, data reads of 0x0D, and any data access at an index above 0x0D pulse `err` for one cycle. Reads among these return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_sel | input | 1 | 0 selects the index port, 1 the data port |
| rd_en | input | 1 | Read strobe for the selected port |
| wr_en | input | 1 | Write strobe for the selected port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte, valid the cycle after `rd_en` |
| err | output | 1 | One-cycle pulse after an unsupported access |
| irq | output | 1 | Periodic interrupt request, high while an event is pending |

## Verification
On every cycle, the bound checker watches several local properties. Alarm and fixed-field read values must be right, an unsupported control write must be followed by an error, the index must read back, `irq` may rise only while enabled, and `irq` may fall only after a flag read. Other behaviours need history that only the bench's scenarios can show. These are the read-to-read toggling of the update flag, the exact DIV-cycle latency and period of events, phase preservation when the enable is rewritten, and the silence after disabling.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] IX_CTLA = 8'h0A;
  localparam logic [7:0] IX_CTLB = 8'h0B;
  localparam logic [7:0] IX_CTLC = 8'h0C;
  localparam logic [7:0] IX_CTLD = 8'h0D;

  // fixed rate/timebase field returned by control A
  localparam logic [6:0] CTLA_RATE  = 7'h26;
  // control B bits that must always read set
  localparam logic [7:0] CTLB_FIXED = 8'h06;
  localparam logic [7:0] CTLB_PIE   = 8'h40;
  localparam logic [7:0] CTLB_SQW   = 8'h08;

  typedef enum logic [2:0] {
    K_TIME,
    K_ALARM,
    K_CTLA,
    K_CTLB,
    K_CTLC,
    K_CTLD,
    K_BAD
  } loc_kind_e;

  function automatic loc_kind_e classify(input logic [7:0] ix);
    loc_kind_e k;
    case (ix)
      8'h00, 8'h02, 8'h04,
      8'h06, 8'h07, 8'h08, 8'h09: k = K_TIME;
      8'h01, 8'h03, 8'h05:        k = K_ALARM;
      IX_CTLA:                    k = K_CTLA;
      IX_CTLB:                    k = K_CTLB;
      IX_CTLC:                    k = K_CTLC;
      IX_CTLD:                    k = K_CTLD;
      default:                    k = K_BAD;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  // counter idles at zero while stopped, so a fresh start has full phase
  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/rtc_time_ram.sv
module rtc_time_ram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_acc,
  input  logic              wr_acc,
  input  loc_kind_e         kind,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              tick,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              pie,
  output logic              pend,
  output logic              bad_acc
);
  logic uip;
  logic b_ok;
  logic a_ok;

  assign a_ok = (wdata == {1'b0, CTLA_RATE});
  assign b_ok = ((wdata & ~(CTLB_PIE | CTLB_SQW)) == CTLB_FIXED);

  always_comb begin
    bad_acc = 1'b0;
    if (wr_acc) begin
      case (kind)
        K_CTLA:                bad_acc = !a_ok;
        K_CTLB:                bad_acc = !b_ok;
        K_CTLC, K_CTLD, K_BAD: bad_acc = 1'b1;
        default:               bad_acc = 1'b0;
      endcase
    end else if (rd_acc) begin
      bad_acc = (kind == K_CTLD) || (kind == K_BAD);
    end
  end

  always_comb begin
    case (kind)
      K_CTLA:  ctrl_q = {uip, CTLA_RATE};
      K_CTLB:  ctrl_q = CTLB_FIXED | (pie ? CTLB_PIE : 8'h00);
      K_CTLC:  ctrl_q = {pend, pend, 6'b0};
      default: ctrl_q = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uip  <= 1'b0;
      pie  <= 1'b1;
      pend <= 1'b0;
    end else begin
      if (rd_acc && kind == K_CTLA) uip <= ~uip;
      if (wr_acc && kind == K_CTLB && b_ok) pie <= wdata[6];
      // a new event wins over a clearing read in the same cycle
      if (tick) pend <= 1'b1;
      else if (rd_acc && kind == K_CTLC) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port
  import rtc_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 1048576,
  parameter int PIRQ_HZ     = 1024,
  parameter int RAM_AW      = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       port_sel,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       err,
  output logic       irq
);
  localparam int DIV = CLK_FREQ_HZ / PIRQ_HZ;

  logic [BYTE_W-1:0] idx_q;
  logic              idx_wr, idx_rd, dat_wr, dat_rd;
  loc_kind_e         kind;
  logic [BYTE_W-1:0] ram_q, ctrl_q;
  logic              pie, pend, tick, bad_acc;

  assign idx_wr = wr_en && !port_sel;
  assign idx_rd = rd_en && !port_sel;
  assign dat_wr = wr_en && port_sel;
  assign dat_rd = rd_en && port_sel;
  assign kind   = classify(idx_q);

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (idx_wr) idx_q <= wdata;
  end

  rtc_time_ram #(.AW(RAM_AW), .DW(BYTE_W)) i_ram (
    .clk   (clk),
    .we    (dat_wr && kind == K_TIME),
    .waddr (idx_q[RAM_AW-1:0]),
    .wdata (wdata),
    .raddr (idx_q[RAM_AW-1:0]),
    .rdata (ram_q)
  );

  rtc_prescaler #(.DIV(DIV)) i_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (pie),
    .tick (tick)
  );

  rtc_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .rd_acc  (dat_rd),
    .wr_acc  (dat_wr),
    .kind    (kind),
    .wdata   (wdata),
    .tick    (tick),
    .ctrl_q  (ctrl_q),
    .pie     (pie),
    .pend    (pend),
    .bad_acc (bad_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= bad_acc;
      if (idx_rd) rdata <= idx_q;
      else if (dat_rd) begin
        case (kind)
          K_TIME:         rdata <= ram_q;
          K_ALARM, K_BAD: rdata <= '0;
          default:        rdata <= ctrl_q;
        endcase
      end
    end
  end

  assign irq = pend;
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk (
  input logic       clk,
  input logic       rst,
  input logic       port_sel,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] rdata,
  input logic       err,
  input logic       irq,
  input logic [7:0] idx,
  input logic       pie
);
  // R2
  idx_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !port_sel) |=> (rdata == $past(idx)));

  // R4
  alarm_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && port_sel && (idx == 8'h01 || idx == 8'h03 || idx == 8'h05))
    |=> (rdata == 8'h00));

  // R5
  ctla_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && port_sel && idx == 8'h0A) |=> (rdata[6:0] == 7'h26));

  // R7
  ctlb_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && port_sel && idx == 8'h0B)
    |=> (rdata[7] == 1'b0 && rdata[5:0] == 6'h06));

  // R12
  ctl_wr_err_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_sel && (idx == 8'h0C || idx == 8'h0D)) |=> err);

  // R11
  ctlc_low_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && port_sel && idx == 8'h0C) |=> (rdata[5:0] == 6'h00));

  // R11
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(rd_en && port_sel && idx == 8'h0C));

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(pie));
endmodule

bind rtc_index_port rtc_chk i_rtc_chk (
  .clk      (clk),
  .rst      (rst),
  .port_sel (port_sel),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .rdata    (rdata),
  .err      (err),
  .irq      (irq),
  .idx      (idx_q),
  .pie      (pie)
);

// File: tb/test_rtc_index_port.sv
module test_rtc_index_port;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 16384;
  localparam int RATE_HZ    = 1024;
  localparam int DIV        = CLK_HZ / RATE_HZ;

  // [31:28] requirement, [27:24] 0=write 1=read, [23:16] index,
  // [15:8] write byte or expected read byte, [7:0] expected err
  localparam int NV = 32;
  localparam logic [31:0] VEC [NV] = '{
    32'h30003B00, 32'h30022A00, 32'h30041700, 32'h30060500, // R3 writes
    32'h30071F00, 32'h30080C00, 32'h30096300,
    32'h31003B00, 32'h31022A00, 32'h31041700, 32'h31060500, // R3 reads
    32'h31071F00, 32'h31080C00, 32'h31096300,
    32'h40015500, 32'h41010000, 32'h41030000, 32'h41050000, // R4
    32'h510A2600, 32'h510AA600,                             // R5 toggle
    32'h600A2600, 32'h600A2001,                             // R6
    32'h510A2600,                                           // R5 back to 0
    32'h800B4E00, 32'h710B4600,                             // R8 accept, R7
    32'h800B4701, 32'h810B4600,                             // R8 reject
    32'hC00C0001, 32'hC00D0001, 32'hC10D0001,               // R12
    32'hC10E0001, 32'hC00E1201                              // R12
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       port_sel = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       err, irq;

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_index_port #(.CLK_FREQ_HZ(CLK_HZ), .PIRQ_HZ(RATE_HZ)) i_rtc_index_port (
    .clk(clk), .rst(rst), .port_sel(port_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .err(err), .irq(irq)
  );

  task automatic check(input int req, input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL R%0d %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic idx_wr(input logic [7:0] a);
    @(negedge clk); port_sel = 1'b0; wr_en = 1'b1; wdata = a;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idx_rd();
    @(negedge clk); port_sel = 1'b0; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic dat_wr(input logic [7:0] d);
    @(negedge clk); port_sel = 1'b1; wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic dat_rd();
    @(negedge clk); port_sel = 1'b1; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 4*DIV) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    logic [31:0] v;
    int n, t1, t2;
    repeat (4) @(negedge clk);
    // R1 reset state while held and just after release
    check(1, "rdata in reset", int'(rdata), 0);
    check(1, "err in reset", int'(err), 0);
    check(1, "irq in reset", int'(irq), 0);
    rst = 1'b0;
    @(negedge clk);
    check(1, "irq after release", int'(irq), 0);
    idx_rd();
    check(1, "index after reset", int'(rdata), 0);
    // R7 enable set after reset
    idx_wr(8'h0B); dat_rd();
    check(7, "ctl B after reset", int'(rdata), 8'h46);
    // R2 index readback
    idx_wr(8'h09); idx_rd();
    check(2, "index readback", int'(rdata), 8'h09);
    idx_wr(8'h5C); idx_rd();
    check(2, "index readback", int'(rdata), 8'h5C);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      idx_wr(v[23:16]);
      if (v[24]) begin
        dat_rd();
        check(int'(v[31:28]), $sformatf("read data idx 0x%0h", v[23:16]), int'(rdata), int'(v[15:8]));
      end else begin
        dat_wr(v[15:8]);
      end
      check(int'(v[31:28]), $sformatf("err idx 0x%0h", v[23:16]), int'(err), int'(v[7:0]));
    end

    // R10 disabled: no events once the flag is cleared
    idx_wr(8'h0B); dat_wr(8'h06);
    idx_wr(8'h0C); dat_rd();
    repeat (3*DIV) @(negedge clk);
    check(10, "irq while disabled", int'(irq), 0);
    dat_rd();
    check(10, "flags while disabled", int'(rdata), 8'h00);

    // R9 first event DIV cycles after enabling
    idx_wr(8'h0B); dat_wr(8'h46);
    wait_irq(n);
    t1 = cyc;
    check(9, "cycles to first event", n, DIV);
    // R11 flag read and clear
    idx_wr(8'h0C); dat_rd();
    check(11, "flags pending", int'(rdata), 8'hC0);
    check(11, "irq after flag read", int'(irq), 0);
    dat_rd();
    check(11, "flags after clear", int'(rdata), 8'h00);
    // R9 rewriting enable keeps the phase
    idx_wr(8'h0B); dat_wr(8'h4E);
    wait_irq(n);
    t2 = cyc;
    check(9, "event period with rewrite", t2 - t1, DIV);
    check(9, "irq raised", int'(irq), 1);

    summary();
  end
endmodule